// File: doc/BRIEF.md
# Warm Reset Sequencer

This block turns any one of several warm-reset requests into an ordered reset sequence. The requests come from a software bit, an external reset pin, a fabric request and four watchdogs. The sequence first optionally warns up to five peripheral agents through request/acknowledge handshakes, one agent at a time. Each handshake is bounded by a timeout. The block then asserts the clock-manager reset and the other resets together, and drives the external reset pin for a programmed number of cycles. It releases the clock-manager reset first. The remaining resets follow after a programmed gap.

A sticky status word records which sources requested a reset and which handshakes timed out. Software clears selected bits by writing a mask with ones in the positions to clear. Only one sequence runs at a time. A request that arrives while a sequence is running only records its cause.

Top module: `warm_rst_seq`

## Requirements
- R1: A request input high at a clock edge sets its status bit at that edge: pin at bit 8, fabric at bit 9, software at bit 10, watchdogs 0..3 at bits 12..15. This also happens while a sequence is running.
- R2: After a request in idle, the enabled handshakes are issued one at a time in this order. Slot 0 is SDRAM self-refresh, slot 1 is trace stall, slot 2 is the FPGA-manager agent, slot 3 is the scan-manager agent and slot 4 is fabric. Enable bit i, request bit i and acknowledge bit i all belong to slot i. A disabled slot is never requested.
- R3: A handshake request stays high until its acknowledge is sampled or until HS_TIMEOUT (1024) cycles have passed. On a timeout the sequence continues and a status bit is set: slot 0 at bit 24, slot 2 at 25, slot 3 at 26, slot 4 at 27, slot 1 at 28. An acknowledge sets no status bit.
- R4: After the last handshake slot, `clkmgr_rst_o` and `periph_rst_o` rise in the same cycle. The clock-manager reset stays high for ASSERT_CYC (4) cycles. No handshake request is high while `periph_rst_o` is high.
- R5: `periph_rst_o` falls `rel_dly_i` cycles after `clkmgr_rst_o` falls. A value below 17 is treated as 17.
- R6: `ext_rst_o` rises together with `periph_rst_o` and stays high for exactly `pin_len_i` cycles. A length of 0 leaves the pin low for the whole sequence.
- R7: Status bits are sticky. A cycle with `clr_we_i` high clears the bits that are set in `clr_mask_i`. A bit set in the same cycle stays set. Unimplemented bits read 0.
- R8: A request during a running sequence starts no second sequence and does not restart a handshake; it only records its cause.
- R9: After reset, all outputs are low and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| sw_req_i | input | 1 | Software warm-reset request |
| pin_req_i | input | 1 | External pin warm-reset request |
| fab_req_i | input | 1 | Fabric warm-reset request |
| wdt_req_i | input | 4 | Watchdog warm-reset requests |
| hs_en_i | input | 5 | Handshake enable per slot |
| rel_dly_i | input | 8 | Gap between clock-manager and other reset release |
| pin_len_i | input | 20 | External pin assertion length in cycles |
| hs_req_o | output | 5 | Handshake requests per slot |
| hs_ack_i | input | 5 | Handshake acknowledges per slot |
| clkmgr_rst_o | output | 1 | Clock-manager reset |
| periph_rst_o | output | 1 | Reset for all other hardware-controlled logic |
| ext_rst_o | output | 1 | External reset pin drive, active high |
| clr_we_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 32 | Status bits to clear |
| status_o | output | 32 | Sticky cause and timeout status |

## Verification
Two sets of functions can fall in the same cycle. The first is a status set and a status clear on the same bit. The bench provokes it by raising the software request and the clear strobe, with that bit in the mask, on one edge; the bit must read 1 afterwards. The second is a new request arriving during a sequence that is already waiting on a handshake. It is judged by the status word and by counting rises of the reset and request cycles: exactly one reset and one undisturbed timeout window must appear.

// File: rtl/warm_rst_seq.sv
module warm_rst_seq #(
  parameter int HS_TIMEOUT = 1024,
  parameter int ASSERT_CYC = 4,
  parameter int DLY_W      = 8,
  parameter int DLY_MIN    = 17,
  parameter int PIN_W      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req_i,
  input  logic             pin_req_i,
  input  logic             fab_req_i,
  input  logic [3:0]       wdt_req_i,
  input  logic [4:0]       hs_en_i,
  input  logic [DLY_W-1:0] rel_dly_i,
  input  logic [PIN_W-1:0] pin_len_i,
  output logic [4:0]       hs_req_o,
  input  logic [4:0]       hs_ack_i,
  output logic             clkmgr_rst_o,
  output logic             periph_rst_o,
  output logic             ext_rst_o,
  input  logic             clr_we_i,
  input  logic [31:0]      clr_mask_i,
  output logic [31:0]      status_o
);
  localparam int TW = $clog2(HS_TIMEOUT);
  localparam int CW = (TW > DLY_W) ? TW : DLY_W;
  localparam int LAST = 4;
  localparam logic [31:0] IMPL = 32'h1F00_F700;

  typedef enum logic [2:0] {S_IDLE, S_HS, S_ASRT, S_REL, S_DRAIN} st_t;

  st_t              st;
  logic [2:0]       idx;
  logic [CW-1:0]    cnt;
  logic [PIN_W-1:0] pcnt;
  logic [DLY_W-1:0] dly_eff;
  logic [4:0]       tmo_pos;
  logic [31:0]      set_v;

  wire any_req  = sw_req_i | pin_req_i | fab_req_i | (|wdt_req_i);
  wire slot_en  = hs_en_i[idx];
  wire slot_ack = hs_ack_i[idx];
  wire tmo      = (cnt == CW'(HS_TIMEOUT - 1));
  wire slot_end = !slot_en || slot_ack || tmo;

  assign dly_eff      = (rel_dly_i < DLY_W'(DLY_MIN)) ? DLY_W'(DLY_MIN) : rel_dly_i;
  assign hs_req_o     = (st == S_HS && slot_en) ? (5'd1 << idx) : 5'd0;
  assign clkmgr_rst_o = (st == S_ASRT);
  assign periph_rst_o = (st == S_ASRT) || (st == S_REL);
  assign ext_rst_o    = (pcnt != '0);

  always_comb begin
    case (idx)
      3'd0:    tmo_pos = 5'd24;
      3'd1:    tmo_pos = 5'd28;
      3'd2:    tmo_pos = 5'd25;
      3'd3:    tmo_pos = 5'd26;
      default: tmo_pos = 5'd27;
    endcase
    set_v        = '0;
    set_v[8]     = pin_req_i;
    set_v[9]     = fab_req_i;
    set_v[10]    = sw_req_i;
    set_v[15:12] = wdt_req_i;
    if (st == S_HS && slot_en && !slot_ack && tmo) set_v[tmo_pos] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      cnt      <= '0;
      pcnt     <= '0;
      status_o <= '0;
    end else begin
      status_o <= ((status_o & ~(clr_we_i ? clr_mask_i : 32'd0)) | set_v) & IMPL;
      if (pcnt != '0) pcnt <= pcnt - 1'b1;
      case (st)
        S_IDLE: if (any_req) begin
          st  <= S_HS;
          idx <= '0;
          cnt <= '0;
        end
        S_HS: if (slot_end) begin
          cnt <= '0;
          if (idx == 3'(LAST)) begin
            st   <= S_ASRT;
            pcnt <= pin_len_i;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_ASRT: if (cnt == CW'(ASSERT_CYC - 1)) begin
          st  <= S_REL;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_REL: if (cnt == CW'(dly_eff - 1'b1)) begin
          st  <= S_DRAIN;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_DRAIN: if (pcnt == '0) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module warm_rst_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  hs_req_o,
  input logic        clkmgr_rst_o,
  input logic        periph_rst_o,
  input logic        ext_rst_o,
  input logic        clr_we_i,
  input logic [31:0] status_o
);
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hs_req_o)); // R2
  AST_NO_REQ_IN_RST: assert property (@(posedge clk) disable iff (!rst_n) periph_rst_o |-> hs_req_o == 5'd0); // R4
  AST_RST_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) $rose(periph_rst_o) |-> $rose(clkmgr_rst_o)); // R4
  AST_CLK_FIRST: assert property (@(posedge clk) disable iff (!rst_n) clkmgr_rst_o |-> periph_rst_o); // R5
  AST_PIN_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n) $rose(ext_rst_o) |-> $rose(periph_rst_o)); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !clr_we_i |=> (status_o & $past(status_o)) == $past(status_o)); // R7
endmodule

bind warm_rst_seq warm_rst_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hs_req_o(hs_req_o), .clkmgr_rst_o(clkmgr_rst_o),
  .periph_rst_o(periph_rst_o), .ext_rst_o(ext_rst_o), .clr_we_i(clr_we_i), .status_o(status_o)
);

// File: tb/warm_rst_seq_tb_top.sv
`timescale 1ns/1ps
module warm_rst_seq_tb_top;
  localparam int TMO = 1024;
  localparam int ACYC = 4;

  logic clk = 0, rst_n = 0;
  logic sw_req = 0, pin_req = 0, fab_req = 0;
  logic [3:0] wdt_req = 0;
  logic [4:0] hs_en = 0, hs_ack = 0, hs_req, ack_mask = 0;
  logic [7:0] rel_dly = 8'd20;
  logic [19:0] pin_len = 20'd3;
  logic clkmgr_rst, periph_rst, ext_rst, clr_we = 0;
  logic [31:0] clr_mask = 0, status;

  int checks = 0, fails = 0, cyc = 0;
  int req_cyc [5];
  int clk_cyc, rel_cyc, pin_cyc, rises, misalign, ord;
  logic [4:0] prev_req = 0;
  logic prev_per = 0, prev_ext = 0;

  always #2.5 clk = ~clk;

  warm_rst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req), .pin_req_i(pin_req), .fab_req_i(fab_req),
    .wdt_req_i(wdt_req), .hs_en_i(hs_en), .rel_dly_i(rel_dly), .pin_len_i(pin_len),
    .hs_req_o(hs_req), .hs_ack_i(hs_ack), .clkmgr_rst_o(clkmgr_rst), .periph_rst_o(periph_rst),
    .ext_rst_o(ext_rst), .clr_we_i(clr_we), .clr_mask_i(clr_mask), .status_o(status)
  );

  always @(negedge clk) hs_ack <= hs_req & ack_mask;

  always @(negedge clk) begin
    for (int i = 0; i < 5; i++) if (hs_req[i]) req_cyc[i] = req_cyc[i] + 1;
    if (hs_req != 0 && hs_req != prev_req)
      for (int i = 0; i < 5; i++) if (hs_req[i]) ord = ord * 8 + i + 1;
    if (clkmgr_rst) clk_cyc = clk_cyc + 1;
    if (!clkmgr_rst && periph_rst) rel_cyc = rel_cyc + 1;
    if (ext_rst) pin_cyc = pin_cyc + 1;
    if (periph_rst && !prev_per) rises = rises + 1;
    if (ext_rst && !prev_ext && !(periph_rst && !prev_per)) misalign = misalign + 1;
    prev_req = hs_req; prev_per = periph_rst; prev_ext = ext_rst;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 190000", cyc);
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    for (int i = 0; i < 5; i++) req_cyc[i] = 0;
    clk_cyc = 0; rel_cyc = 0; pin_cyc = 0; rises = 0; misalign = 0; ord = 0;
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw_req = 1;
    @(negedge clk) sw_req = 0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!(rises >= 1 && !periph_rst && !ext_rst) && n < 20000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk) begin clr_we = 1; clr_mask = 32'hFFFF_FFFF; end
    @(negedge clk) begin clr_we = 0; clr_mask = 0; end
  endtask

  task automatic run_seq(logic [4:0] en, logic [4:0] am, logic [7:0] dly, logic [19:0] plen);
    int eo, ed;
    logic [31:0] es;
    hs_en = en; ack_mask = am; rel_dly = dly; pin_len = plen;
    clear_all();
    mon_clear();
    pulse_sw();
    wait_done();
    eo = 0; es = 32'h400;
    for (int i = 0; i < 5; i++) if (en[i]) eo = eo * 8 + i + 1;
    chk("R2 handshake order", ord, eo);
    for (int i = 0; i < 5; i++)
      chk($sformatf("R3 slot %0d request cycles", i), req_cyc[i], !en[i] ? 0 : (am[i] ? 1 : TMO));
    if (en[0] && !am[0]) es[24] = 1;
    if (en[1] && !am[1]) es[28] = 1;
    if (en[2] && !am[2]) es[25] = 1;
    if (en[3] && !am[3]) es[26] = 1;
    if (en[4] && !am[4]) es[27] = 1;
    chk("R3 timeout status", status, es);
    chk("R4 clkmgr hold", clk_cyc, ACYC);
    ed = (dly < 17) ? 17 : dly;
    chk("R5 release gap", rel_cyc, ed);
    chk("R6 pin length", pin_cyc, plen);
    chk("R6 pin aligned", misalign, 0);
    chk("R8 single sequence", rises, 1);
  endtask

  task automatic cause_test(int b);
    int k;
    clear_all();
    hs_en = 0; mon_clear();
    @(negedge clk) begin
      case (b)
        8:  pin_req = 1;
        9:  fab_req = 1;
        10: sw_req = 1;
        default: wdt_req[b-12] = 1;
      endcase
    end
    @(negedge clk) begin pin_req = 0; fab_req = 0; sw_req = 0; wdt_req = 0; end
    k = b;
    chk($sformatf("R1 cause bit %0d", k), status, 32'd1 << b);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 status after reset", status, 0);
    chk("R9 outputs after reset", {27'd0, hs_req}, 0);
    chk("R9 resets after reset", {clkmgr_rst, periph_rst, ext_rst}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int b = 8; b <= 15; b++) if (b != 11) cause_test(b);

    for (int e = 0; e < 32; e++) run_seq(5'(e), 5'h1F, 8'd20, 20'd3);
    for (int i = 0; i < 5; i++) run_seq(5'h1F, 5'h1F & ~(5'd1 << i), 8'd18, 20'd2);
    run_seq(5'h1F, 5'h00, 8'd30, 20'd5);

    run_seq(5'h00, 5'h1F, 8'd0, 20'd1);
    run_seq(5'h00, 5'h1F, 8'd16, 20'd0);
    run_seq(5'h00, 5'h1F, 8'd17, 20'd7);
    run_seq(5'h03, 5'h1F, 8'd200, 20'd1000);
    run_seq(5'h00, 5'h1F, 8'd255, 20'd40);

    clear_all();
    @(negedge clk) begin sw_req = 1; pin_req = 1; hs_en = 0; end
    @(negedge clk) begin sw_req = 0; pin_req = 0; end
    wait_done();
    chk("R7 sticky after sequence", status, 32'h500);
    @(negedge clk) begin clr_we = 1; clr_mask = 32'h100; end
    @(negedge clk) begin clr_we = 0; clr_mask = 0; end
    chk("R7 selective clear", status, 32'h400);
    @(negedge clk) begin clr_we = 1; clr_mask = 32'hFFFF_FFFF; end
    @(negedge clk) begin clr_we = 0; clr_mask = 0; end
    chk("R7 full clear", status, 0);

    mon_clear();
    @(negedge clk) begin sw_req = 1; clr_we = 1; clr_mask = 32'h400; end
    @(negedge clk) begin sw_req = 0; clr_we = 0; clr_mask = 0; end
    chk("R7 set wins over clear", status, 32'h400);
    wait_done();

    clear_all();
    hs_en = 5'h01; ack_mask = 0; rel_dly = 8'd20; pin_len = 20'd2;
    mon_clear();
    pulse_sw();
    repeat (10) @(negedge clk);
    @(negedge clk) begin wdt_req = 4'b0100; fab_req = 1; end
    @(negedge clk) begin wdt_req = 0; fab_req = 0; end
    chk("R8 cause logged mid-sequence", status, 32'h4600);
    repeat (30) @(negedge clk);
    @(negedge clk) sw_req = 1;
    @(negedge clk) sw_req = 0;
    wait_done();
    chk("R8 one reset only", rises, 1);
    chk("R8 handshake not restarted", req_cyc[0], TMO);
    chk("R3 slot 0 timeout bit", status, 32'h0100_4600);

    summary();
  end
endmodule